// File: doc/BRIEF.md
# CAN Error-State Flag and Interrupt Unit

This block sits beside the error counters of a CAN controller. Each cycle it sorts the transmit and receive error counts into four coarse categories (normal, warning, passive, bus-off). It reports one category for the receiver and one for the transmitter through a small status register. When either reported category moves, a status-change flag is raised. That flag blocks further updates: the reported codes stay frozen while the flag is pending, and they follow the counters again only after software clears it. A second flag records bus activity seen during sleep when wake-up is enabled.

Software reads the status register at any time. It clears a flag by writing 1 to that flag's bit. Each flag has its own enable input, and the enable gates that flag's interrupt line. While the controller is in initialization mode (request and acknowledge both high), both flags are held cleared and writes are ignored. The reported codes keep working during that time.

The block has no streaming data path. All of its pins are plain control and status signals with no handshake, and there is no back-pressure.

Top module: `can_errstat_flags`

## Requirements
- R1: The receiver code is 2'b00 for a receive count of 0 to 95, 2'b01 for 96 to 127 and 2'b10 for 128 to 255. It is 2'b11 whenever the transmit count exceeds 255, whatever the receive count.
- R2: The transmitter code is 2'b00 for a transmit count of 0 to 95, 2'b01 for 96 to 127, 2'b10 for 128 to 255 and 2'b11 above 255.
- R3: When the status-change flag is clear and the category computed from the counters differs from either reported code, the clock edge loads both codes with the computed categories and sets the flag. A counter change that stays within the same category raises nothing.
- R4: While the status-change flag is set, both reported codes hold their values through any counter change. After a clear, the codes take the current categories on the next edge, and the flag is set again on that same edge if they differ.
- R5: Register layout: bit 0 is the status-change flag, bit 1 is the wake-up flag, bits [3:2] are the receiver code, bits [5:4] are the transmitter code, and bits [7:6] read 0. Writing 1 to bit 0 or bit 1 clears that flag on the next edge. Writing 0 leaves the flag unchanged. Writes to bits [7:2] have no effect.
- R6: If a flag's set condition and a write-1 clear of that flag happen in the same cycle, the flag stays set.
- R7: While init request and init acknowledge are both high, both flags are held at 0 and writes are ignored. The codes keep following the counters without raising the flag. With only one of the two signals high, the block works normally.
- R8: The wake-up flag is set on an edge where sleep mode, wake-up enable and bus activity are all high. It stays set after the activity ends, until it is cleared.
- R9: The status-change interrupt is high exactly when its flag and its enable are both 1. The wake-up interrupt is high exactly when its flag and its enable are both 1.
- R10: After reset the register reads 0 (both codes 2'b00, both flags 0) and both interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_err_cnt | input | 9 | Transmit error count |
| rx_err_cnt | input | 8 | Receive error count |
| sleep_mode | input | 1 | Controller is in sleep |
| wake_en | input | 1 | Wake-up on bus activity enabled |
| bus_activity | input | 1 | Activity seen on the CAN bus |
| init_req | input | 1 | Initialization mode requested |
| init_ack | input | 1 | Initialization mode acknowledged |
| reg_wr_en | input | 1 | Status register write strobe |
| reg_wr_data | input | 8 | Write data (1 in a flag bit clears it) |
| reg_rd_data | output | 8 | Status register read value |
| stat_ie | input | 1 | Status-change interrupt enable |
| wake_ie | input | 1 | Wake-up interrupt enable |
| rx_code | output | 2 | Reported receiver code |
| tx_code | output | 2 | Reported transmitter code |
| stat_irq | output | 1 | Status-change interrupt request |
| wake_irq | output | 1 | Wake-up interrupt request |

## Verification
The assertions check on every cycle that the codes are frozen while the change flag is pending, and that every movement of the codes outside init mode comes with a raised flag. They also check that bus-off forces both codes together, that a write of 0 keeps a flag, that a wake-up set beats a same-cycle clear, that init mode empties the flags, and that no interrupt is raised without its flag and enable. Only the directed scenarios can show the category boundaries at each threshold value. They also show the exact edge on which codes resume and the flag is raised again after a clear, and that counter changes within one category are quiet. The remaining scenario-only behaviours are the read layout of the register and the codes continuing to track during init mode.

// File: rtl/can_errstat_pkg.sv
package can_errstat_pkg;
  typedef enum logic [1:0] {
    ST_OK      = 2'b00,
    ST_WARN    = 2'b01,
    ST_PASSIVE = 2'b10,
    ST_BUSOFF  = 2'b11
  } err_cat_e;

  localparam int unsigned REG_W     = 8;
  localparam int unsigned CHG_BIT   = 0;
  localparam int unsigned WAKE_BIT  = 1;
  localparam int unsigned RX_LSB    = 2;
  localparam int unsigned TX_LSB    = 4;
endpackage

// File: rtl/can_errstat_classify.sv
module can_errstat_classify
  import can_errstat_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned WARN_LVL    = 96,
  parameter int unsigned PASSIVE_LVL = 128,
  parameter int unsigned BUSOFF_LVL  = 256
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic             force_busoff,
  output err_cat_e         cat
);
  localparam logic [CNT_W:0] WARN_C    = WARN_LVL[CNT_W:0];
  localparam logic [CNT_W:0] PASSIVE_C = PASSIVE_LVL[CNT_W:0];
  localparam bit             REACH     = (CNT_W > $clog2(BUSOFF_LVL));

  logic [CNT_W:0] cnt_x;
  logic           over;

  assign cnt_x = {1'b0, cnt};

  generate
    if (REACH) begin : g_busoff
      localparam logic [CNT_W:0] BUSOFF_C = BUSOFF_LVL[CNT_W:0];
      assign over = (cnt_x >= BUSOFF_C);
    end else begin : g_no_busoff
      assign over = 1'b0;
    end
  endgenerate

  always_comb begin
    if (force_busoff || over)     cat = ST_BUSOFF;
    else if (cnt_x >= PASSIVE_C)  cat = ST_PASSIVE;
    else if (cnt_x >= WARN_C)     cat = ST_WARN;
    else                          cat = ST_OK;
  end
endmodule

// File: rtl/can_errstat_change.sv
module can_errstat_change
  import can_errstat_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  err_cat_e cat_rx,
  input  err_cat_e cat_tx,
  input  logic     in_init,
  input  logic     clr_req,
  output logic     chg_flag,
  output err_cat_e rep_rx,
  output err_cat_e rep_tx
);
  logic differ;

  assign differ = (cat_rx != rep_rx) || (cat_tx != rep_tx);

  // codes load only while no change is pending (blocking behaviour)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep_rx <= ST_OK;
      rep_tx <= ST_OK;
    end else if (!chg_flag) begin
      rep_rx <= cat_rx;
      rep_tx <= cat_tx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    chg_flag <= 1'b0;
    else if (in_init)              chg_flag <= 1'b0;
    else if (!chg_flag && differ)  chg_flag <= 1'b1;
    else if (clr_req)              chg_flag <= 1'b0;
  end
endmodule

// File: rtl/can_errstat_wake.sv
module can_errstat_wake (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_mode,
  input  logic wake_en,
  input  logic bus_activity,
  input  logic in_init,
  input  logic clr_req,
  output logic wake_flag
);
  logic set_req;

  assign set_req = sleep_mode && wake_en && bus_activity;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wake_flag <= 1'b0;
    else if (in_init)  wake_flag <= 1'b0;
    else if (set_req)  wake_flag <= 1'b1;
    else if (clr_req)  wake_flag <= 1'b0;
  end
endmodule

// File: rtl/can_errstat_flags.sv
module can_errstat_flags
  import can_errstat_pkg::*;
#(
  parameter int unsigned TEC_W       = 9,
  parameter int unsigned REC_W       = 8,
  parameter int unsigned WARN_LVL    = 96,
  parameter int unsigned PASSIVE_LVL = 128,
  parameter int unsigned BUSOFF_LVL  = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TEC_W-1:0] tx_err_cnt,
  input  logic [REC_W-1:0] rx_err_cnt,
  input  logic             sleep_mode,
  input  logic             wake_en,
  input  logic             bus_activity,
  input  logic             init_req,
  input  logic             init_ack,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wr_data,
  output logic [REG_W-1:0] reg_rd_data,
  input  logic             stat_ie,
  input  logic             wake_ie,
  output logic [1:0]       rx_code,
  output logic [1:0]       tx_code,
  output logic             stat_irq,
  output logic             wake_irq
);
  err_cat_e cat_rx, cat_tx, rep_rx, rep_tx;
  logic     tx_busoff, in_init, clr_chg, clr_wake;
  logic     chg_flag, wake_flag;
  logic     unused_wr_bits;

  assign in_init        = init_req && init_ack;
  assign clr_chg        = reg_wr_en && !in_init && reg_wr_data[CHG_BIT];
  assign clr_wake       = reg_wr_en && !in_init && reg_wr_data[WAKE_BIT];
  assign unused_wr_bits = ^reg_wr_data[REG_W-1:2];

  can_errstat_classify #(
    .CNT_W(TEC_W), .WARN_LVL(WARN_LVL),
    .PASSIVE_LVL(PASSIVE_LVL), .BUSOFF_LVL(BUSOFF_LVL)
  ) u_tx_cls (
    .cnt(tx_err_cnt), .force_busoff(1'b0), .cat(cat_tx)
  );

  assign tx_busoff = (cat_tx == ST_BUSOFF);

  can_errstat_classify #(
    .CNT_W(REC_W), .WARN_LVL(WARN_LVL),
    .PASSIVE_LVL(PASSIVE_LVL), .BUSOFF_LVL(BUSOFF_LVL)
  ) u_rx_cls (
    .cnt(rx_err_cnt), .force_busoff(tx_busoff), .cat(cat_rx)
  );

  can_errstat_change u_change (
    .clk(clk), .rst_n(rst_n),
    .cat_rx(cat_rx), .cat_tx(cat_tx),
    .in_init(in_init), .clr_req(clr_chg),
    .chg_flag(chg_flag), .rep_rx(rep_rx), .rep_tx(rep_tx)
  );

  can_errstat_wake u_wake (
    .clk(clk), .rst_n(rst_n),
    .sleep_mode(sleep_mode), .wake_en(wake_en), .bus_activity(bus_activity),
    .in_init(in_init), .clr_req(clr_wake), .wake_flag(wake_flag)
  );

  assign rx_code = rep_rx;
  assign tx_code = rep_tx;

  always_comb begin
    reg_rd_data                   = '0;
    reg_rd_data[CHG_BIT]          = chg_flag;
    reg_rd_data[WAKE_BIT]         = wake_flag;
    reg_rd_data[RX_LSB+1:RX_LSB]  = rep_rx;
    reg_rd_data[TX_LSB+1:TX_LSB]  = rep_tx;
  end

  assign stat_irq = chg_flag && stat_ie;
  assign wake_irq = wake_flag && wake_ie;
endmodule

// File: rtl/can_errstat_flags_chk.sv
module can_errstat_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       init_req,
  input logic       init_ack,
  input logic       sleep_mode,
  input logic       wake_en,
  input logic       bus_activity,
  input logic       reg_wr_en,
  input logic [1:0] wr_bits,
  input logic [1:0] flags,
  input logic       stat_ie,
  input logic       wake_ie,
  input logic [1:0] rx_code,
  input logic [1:0] tx_code,
  input logic       stat_irq,
  input logic       wake_irq
);
  logic in_init;
  assign in_init = init_req && init_ack;

  // R1: bus-off in the transmitter forces the receiver code too
  p_busoff_both_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_code == 2'b11) |-> (rx_code == 2'b11));

  // R3: any code movement outside init mode comes with the change flag
  p_move_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable({rx_code, tx_code}) && !$past(in_init)) |-> flags[0]);

  // R4: codes frozen while the change flag is pending
  p_codes_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flags[0] |=> $stable({rx_code, tx_code}));

  // R5: writing 0 to the change flag keeps it
  p_write0_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_init && reg_wr_en && !wr_bits[0] && flags[0]) |=> flags[0]);

  // R6: a wake-up set condition wins over any clear
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_init && sleep_mode && wake_en && bus_activity) |=> flags[1]);

  // R7: init mode empties both flags
  p_init_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_init |=> (flags == 2'b00));

  // R9: no interrupt without its flag and enable
  p_stat_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_irq |-> (flags[0] && stat_ie));
  p_wake_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> (flags[1] && wake_ie));
endmodule

bind can_errstat_flags can_errstat_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .init_req(init_req), .init_ack(init_ack),
  .sleep_mode(sleep_mode), .wake_en(wake_en), .bus_activity(bus_activity),
  .reg_wr_en(reg_wr_en), .wr_bits(reg_wr_data[1:0]), .flags(reg_rd_data[1:0]),
  .stat_ie(stat_ie), .wake_ie(wake_ie), .rx_code(rx_code), .tx_code(tx_code),
  .stat_irq(stat_irq), .wake_irq(wake_irq)
);

// File: tb/can_errstat_flags_test.sv
`timescale 1ns/100ps
module can_errstat_flags_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] tx_err_cnt = '0;
  logic [7:0] rx_err_cnt = '0;
  logic       sleep_mode = 1'b0, wake_en = 1'b0, bus_activity = 1'b0;
  logic       init_req = 1'b0, init_ack = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wr_data = '0;
  logic [7:0] reg_rd_data;
  logic       stat_ie = 1'b0, wake_ie = 1'b0;
  logic [1:0] rx_code, tx_code;
  logic       stat_irq, wake_irq;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  can_errstat_flags uut (
    .clk(clk), .rst_n(rst_n), .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt),
    .sleep_mode(sleep_mode), .wake_en(wake_en), .bus_activity(bus_activity),
    .init_req(init_req), .init_ack(init_ack), .reg_wr_en(reg_wr_en),
    .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
    .stat_ie(stat_ie), .wake_ie(wake_ie), .rx_code(rx_code), .tx_code(tx_code),
    .stat_irq(stat_irq), .wake_irq(wake_irq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr_en = 1'b1;
    reg_wr_data = d;
    tick();
    reg_wr_en = 1'b0;
    reg_wr_data = '0;
  endtask

  // drive counters, expect a category move, then clear the change flag
  task automatic move(input string req, input int rx, input int tx, input int erx, input int etx);
    rx_err_cnt = rx[7:0];
    tx_err_cnt = tx[8:0];
    tick();
    chk(req, "rx code", int'(rx_code), erx);
    chk(req, "tx code", int'(tx_code), etx);
    chk("R3", "change flag raised", int'(reg_rd_data[0]), 1);
    wr(8'h01);
    chk("R5", "change flag cleared", int'(reg_rd_data[0]), 0);
  endtask

  // drive counters within the same category: nothing moves
  task automatic quiet(input string req, input int rx, input int tx, input int erx, input int etx);
    rx_err_cnt = rx[7:0];
    tx_err_cnt = tx[8:0];
    tick();
    chk(req, "rx code steady", int'(rx_code), erx);
    chk(req, "tx code steady", int'(tx_code), etx);
    chk("R3", "no flag in same category", int'(reg_rd_data[0]), 0);
  endtask

  task automatic t_reset();
    tick();
    chk("R10", "register after reset", int'(reg_rd_data), 0);
    chk("R10", "stat_irq after reset", int'(stat_irq), 0);
    chk("R10", "wake_irq after reset", int'(wake_irq), 0);
  endtask

  task automatic t_rx_enc();
    quiet("R1", 95, 0, 0, 0);
    move("R1", 96, 0, 1, 0);
    quiet("R1", 127, 0, 1, 0);
    move("R1", 128, 0, 2, 0);
    quiet("R1", 255, 0, 2, 0);
    move("R1", 0, 0, 0, 0);
  endtask

  task automatic t_tx_enc();
    quiet("R2", 0, 95, 0, 0);
    move("R2", 0, 96, 0, 1);
    move("R2", 0, 128, 0, 2);
    quiet("R2", 0, 255, 0, 2);
    move("R1", 50, 256, 3, 3);
    quiet("R2", 200, 511, 3, 3);
    move("R2", 0, 0, 0, 0);
  endtask

  task automatic t_block();
    rx_err_cnt = 8'd96;
    tick();
    chk("R4", "first move rx", int'(rx_code), 1);
    rx_err_cnt = 8'd200;
    tick();
    tick();
    chk("R4", "rx frozen", int'(rx_code), 1);
    tx_err_cnt = 9'd300;
    tick();
    chk("R4", "tx frozen", int'(tx_code), 0);
    chk("R4", "rx still frozen", int'(rx_code), 1);
    wr(8'h01);
    chk("R4", "flag low after clear", int'(reg_rd_data[0]), 0);
    chk("R4", "codes not yet updated", int'(rx_code), 1);
    tick();
    chk("R4", "rx resumes", int'(rx_code), 3);
    chk("R4", "tx resumes", int'(tx_code), 3);
    chk("R4", "flag re-raised", int'(reg_rd_data[0]), 1);
    rx_err_cnt = 8'd0;
    tx_err_cnt = 9'd0;
    wr(8'h01);
    tick();
    chk("R4", "back to ok", int'({tx_code, rx_code}), 0);
    wr(8'h01);
  endtask

  task automatic t_write_rules();
    rx_err_cnt = 8'd96;
    tick();
    wr(8'h00);
    chk("R5", "write 0 keeps flag", int'(reg_rd_data[0]), 1);
    wr(8'hFC);
    chk("R5", "code bits read-only", int'(reg_rd_data), 8'h05);
    wr(8'h01);
    chk("R5", "layout after clear", int'(reg_rd_data), 8'h04);
    rx_err_cnt = 8'd0;
    tick();
    wr(8'h01);
    chk("R5", "register idle", int'(reg_rd_data), 0);
  endtask

  task automatic t_wake();
    sleep_mode = 1'b1; wake_en = 1'b0; bus_activity = 1'b1;
    tick();
    chk("R8", "no wake when disabled", int'(reg_rd_data[1]), 0);
    sleep_mode = 1'b0; wake_en = 1'b1;
    tick();
    chk("R8", "no wake when awake", int'(reg_rd_data[1]), 0);
    sleep_mode = 1'b1;
    tick();
    chk("R8", "wake set", int'(reg_rd_data[1]), 1);
    wr(8'h02);
    chk("R6", "set wins over clear", int'(reg_rd_data[1]), 1);
    bus_activity = 1'b0;
    tick();
    chk("R8", "wake sticky", int'(reg_rd_data[1]), 1);
    wr(8'h02);
    chk("R5", "wake cleared", int'(reg_rd_data[1]), 0);
  endtask

  task automatic t_irq();
    bus_activity = 1'b1;
    rx_err_cnt = 8'd96;
    tick();
    bus_activity = 1'b0;
    tick();
    chk("R9", "stat_irq masked", int'(stat_irq), 0);
    chk("R9", "wake_irq masked", int'(wake_irq), 0);
    stat_ie = 1'b1;
    #1;
    chk("R9", "stat_irq enabled", int'(stat_irq), 1);
    chk("R9", "wake_irq still masked", int'(wake_irq), 0);
    wake_ie = 1'b1;
    #1;
    chk("R9", "wake_irq enabled", int'(wake_irq), 1);
    wr(8'h03);
    chk("R9", "irqs drop with flags", int'({stat_irq, wake_irq}), 0);
    rx_err_cnt = 8'd0;
    tick();
    wr(8'h01);
  endtask

  task automatic t_init();
    bus_activity = 1'b1;
    rx_err_cnt = 8'd96;
    tick();
    bus_activity = 1'b0;
    init_req = 1'b1;
    tick();
    chk("R7", "request alone keeps flags", int'(reg_rd_data[1:0]), 3);
    init_ack = 1'b1;
    tick();
    chk("R7", "flags held clear", int'(reg_rd_data[1:0]), 0);
    chk("R7", "irqs low in init", int'({stat_irq, wake_irq}), 0);
    rx_err_cnt = 8'd128;
    bus_activity = 1'b1;
    tick();
    tick();
    chk("R7", "codes track in init", int'(rx_code), 2);
    chk("R7", "no flags in init", int'(reg_rd_data[1:0]), 0);
    bus_activity = 1'b0;
    init_req = 1'b0;
    init_ack = 1'b0;
    tick();
    chk("R7", "quiet after exit", int'(reg_rd_data[1:0]), 0);
    rx_err_cnt = 8'd0;
    tick();
    chk("R7", "flag works after exit", int'(reg_rd_data[0]), 1);
    wr(8'h01);
    chk("R7", "write works after exit", int'(reg_rd_data[0]), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_rx_enc();
    t_tx_enc();
    t_block();
    t_write_rules();
    t_wake();
    t_irq();
    t_init();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule